// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Per-Pin Interrupt Detection

This block gives a processor sixteen general-purpose pins on a simple word-addressed register bus. Software writes the values the pins drive and selects which pins are driven. It reads the pin levels after they have passed through a synchroniser. Each pin also carries a 3-bit detection style that turns its synchronised level into an interrupt status bit. That bit goes out on a dedicated interrupt line for the pin.

Five styles are supported: high level, low level, rising edge, falling edge and any edge. Level styles make the status bit follow the qualified level. Edge styles set a sticky status bit, and software clears it by writing a one to that bit. The remaining codes switch detection off for the pin. The style fields for pins 0 to 7 are in the first style register and those for pins 8 to 15 are in the second. Only whole 32-bit words are transferred, so the bus presents a word address.

Top module: `pinbank_gpio`

## Requirements
- R1: After a synchronous reset, with `rst_n` low at a clock edge, the output register and `pin_out` are 0. The direction register and `pin_oe_n` are all ones, so every pin is an input. The status register, `pin_irq` and both style registers are 0.
- R2: The word addresses are 0 output (byte 0x00), 1 direction (0x04), 2 input (0x08), 3 status (0x0C), 4 style-A (0x10) and 5 style-B (0x14). Register bits that are not implemented read 0: bits 31:16 of the pin registers and bits 31:24 of the style registers. Any other word address reads 0, and writes to it have no effect.
- R3: The output register drives `pin_out` and the direction register drives `pin_oe_n`, one cycle after the write. A 0 in a `pin_oe_n` bit means the pin is driven.
- R4: The input register returns `pin_in` through a two-flop synchroniser. A change made before clock edge k reads back after edge k+1 and not before.
- R5: Pin i takes its style from bits [3j+2:3j] with j = i mod 8. Pins 0 to 7 use style-A and pins 8 to 15 use style-B.
- R6: Style 0 (high level) and style 1 (low level) make status bit i equal to the qualified level. It is updated three edges after a pin change, and writes to the status register do not affect it.
- R7: Style 2 (rising) and style 3 (falling) set status bit i three edges after the matching transition. The bit then stays set when the pin moves back, and the opposite transition does not set it.
- R8: Style 4 sets status bit i on either transition.
- R9: Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a new edge in the same cycle as the clear wins.
- R10: Styles 5, 6 and 7 disable detection. Pin activity never sets the status bit, and a write of 1 still clears it.
- R11: `pin_irq[i]` always equals status bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe for one full word |
| bus_addr | input | 4 | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Values driven on the pins |
| pin_oe_n | output | 16 | Per-pin drive enable, 0 drives |
| pin_irq | output | 16 | Per-pin interrupt request |

## Verification
A stale previous-sample flop or a misread style field would show up on `pin_irq` within three edges of the pin change. It would appear as a missing edge, a spurious opposite edge, or a bit that a different pin's activity sets. A status bit that loses its sticky hold, or that clears when it should not, appears at the next read of the status register. Synchroniser depth errors show as the input word arriving one cycle early or late. The directed scenarios therefore sample exactly at the computed edge and one edge before it.

// File: rtl/pinbank_pkg.sv
// Shared constants for the GPIO bank: word addresses and detection style codes.
// Assumes a word-addressed bus with full 32-bit transfers only.
package pinbank_pkg;
    localparam int FIELD_W        = 3;
    localparam int FIELDS_PER_REG = 8;

    localparam int WA_OUT   = 0;
    localparam int WA_DIR   = 1;
    localparam int WA_IN    = 2;
    localparam int WA_STAT  = 3;
    localparam int WA_STYLE = 4;  // first style register, next one follows

    localparam logic [FIELD_W-1:0] STY_HIGH = 3'd0;
    localparam logic [FIELD_W-1:0] STY_LOW  = 3'd1;
    localparam logic [FIELD_W-1:0] STY_RISE = 3'd2;
    localparam logic [FIELD_W-1:0] STY_FALL = 3'd3;
    localparam logic [FIELD_W-1:0] STY_ANY  = 3'd4;
endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is independent; no cross-bit coherence is claimed.
module pinbank_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two register stages, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/pinbank_detect.sv
// Per-pin event detector: turns a synchronised level and a 3-bit style into
// one status bit. Level styles track, edge styles latch until cleared.
// Assumes lvl is already synchronous to clk.
module pinbank_detect
    import pinbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] style,
    input  logic               lvl,
    input  logic               clr,
    output logic               status
);
    logic prev;
    logic hit;
    logic tracks_level;

    // Decode the style into a raw hit and whether the bit tracks a level.
    always_comb begin
        hit          = 1'b0;
        tracks_level = 1'b0;
        case (style)
            STY_HIGH: begin tracks_level = 1'b1; hit = lvl;  end
            STY_LOW:  begin tracks_level = 1'b1; hit = !lvl; end
            STY_RISE: hit = lvl && !prev;
            STY_FALL: hit = !lvl && prev;
            STY_ANY:  hit = lvl ^ prev;
            default:  hit = 1'b0;
        endcase
    end

    // Keep the previous sample and update status; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            status <= 1'b0;
        end else begin
            prev <= lvl;
            if (tracks_level)
                status <= hit;
            else if (hit)
                status <= 1'b1;
            else if (clr)
                status <= 1'b0;
        end
    end

    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STY_RISE && lvl && !prev) |=> status);
    p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STY_FALL && !lvl && prev) |=> status);
    p_high_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STY_HIGH) |=> (status == $past(lvl)));
    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tracks_level && status && !clr) |=> status);
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (style > STY_ANY && !status) |=> !status);
endmodule

// File: rtl/pinbank_gpio.sv
// GPIO bank top: output, direction, synchronised input, sticky/level status
// and per-pin style registers on a word-addressed bus; one irq line per pin.
// Assumes NPINS <= 16 (two style registers) and whole-word transfers.
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int WADDR_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wen,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe_n,
    output logic [NPINS-1:0]   pin_irq
);
    localparam int NSTYLE    = (NPINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int STYLE_W   = FIELDS_PER_REG * FIELD_W;

    logic [NPINS-1:0]                out_q;
    logic [NPINS-1:0]                dir_q;
    logic [NSTYLE-1:0][STYLE_W-1:0]  style_q;
    logic [NPINS-1:0]                lvl_s;
    logic [NPINS-1:0]                stat;
    logic [NPINS-1:0]                clr_vec;
    logic                            wr_out, wr_dir, wr_stat;

    assign wr_out  = bus_wen && (bus_addr == WADDR_W'(WA_OUT));
    assign wr_dir  = bus_wen && (bus_addr == WADDR_W'(WA_DIR));
    assign wr_stat = bus_wen && (bus_addr == WADDR_W'(WA_STAT));
    assign clr_vec = wr_stat ? bus_wdata[NPINS-1:0] : '0;

    // Output data and active-low drive enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '1;
        end else begin
            if (wr_out) out_q <= bus_wdata[NPINS-1:0];
            if (wr_dir) dir_q <= bus_wdata[NPINS-1:0];
        end
    end

    generate
        for (genvar t = 0; t < NSTYLE; t++) begin : g_style
            // One style register holding FIELDS_PER_REG fields.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    style_q[t] <= '0;
                else if (bus_wen && bus_addr == WADDR_W'(WA_STYLE + t))
                    style_q[t] <= bus_wdata[STYLE_W-1:0];
            end
        end
    endgenerate

    pinbank_sync #(.WIDTH(NPINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_s)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            localparam int REG = i / FIELDS_PER_REG;
            localparam int POS = (i % FIELDS_PER_REG) * FIELD_W;
            pinbank_detect det_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .style  (style_q[REG][POS +: FIELD_W]),
                .lvl    (lvl_s[i]),
                .clr    (clr_vec[i]),
                .status (stat[i])
            );
        end
    endgenerate

    // Read multiplexer; unmapped words and unused bits return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            WADDR_W'(WA_OUT):  bus_rdata[NPINS-1:0] = out_q;
            WADDR_W'(WA_DIR):  bus_rdata[NPINS-1:0] = dir_q;
            WADDR_W'(WA_IN):   bus_rdata[NPINS-1:0] = lvl_s;
            WADDR_W'(WA_STAT): bus_rdata[NPINS-1:0] = stat;
            default: begin
                for (int t = 0; t < NSTYLE; t++)
                    if (bus_addr == WADDR_W'(WA_STYLE + t))
                        bus_rdata[STYLE_W-1:0] = style_q[t];
            end
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe_n = dir_q;
    assign pin_irq  = stat;

    p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> (pin_out == $past(bus_wdata[NPINS-1:0])));
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe_n == $past(bus_wdata[NPINS-1:0])));
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_irq == '0 && !wr_stat && $stable(pin_in) && $stable(lvl_s)
         && $stable(style_q) && lvl_s == '0 && style_q == '0)
        |=> (pin_irq == '0));
endmodule

// File: tb/pinbank_gpio_tb.sv
// Directed bench for pinbank_gpio: one task per scenario, each self-checking.
module pinbank_gpio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe_n, pin_irq;

    int checks = 0;
    int errors = 0;
    logic [2:0] sty [16];

    always #4 clk = ~clk;  // 125 MHz

    pinbank_gpio dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe_n(pin_oe_n), .pin_irq(pin_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic apply_styles();
        logic [31:0] a, b;
        a = '0; b = '0;
        for (int i = 0; i < 8; i++) begin
            a[3*i +: 3] = sty[i];
            b[3*i +: 3] = sty[i+8];
        end
        wr(4'd4, a);
        wr(4'd5, b);
    endtask

    task automatic all_disabled();
        for (int i = 0; i < 16; i++) sty[i] = 3'd7;
        apply_styles();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); check("R1 out reg", d, 32'h0);
        rd(4'd1, d); check("R1 dir reg", d, 32'h0000FFFF);
        rd(4'd3, d); check("R1 status", d, 32'h0);
        rd(4'd4, d); check("R1 style-A", d, 32'h0);
        check("R1 pin_oe_n", {16'h0, pin_oe_n}, 32'h0000FFFF);
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 pin_irq", {16'h0, pin_irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(4'd4, 32'hFFFFFFFF);
        rd(4'd4, d); check("R2 style-A unused bits", d, 32'h00FFFFFF);
        wr(4'd5, 32'hFFFFFFFF);
        rd(4'd5, d); check("R2 style-B unused bits", d, 32'h00FFFFFF);
        wr(4'd0, 32'hFFFFA5C3);
        rd(4'd0, d); check("R2 out reg upper bits", d, 32'h0000A5C3);
        check("R3 pin_out", {16'h0, pin_out}, 32'h0000A5C3);
        wr(4'd1, 32'h000000F0);
        check("R3 pin_oe_n active low", {16'h0, pin_oe_n}, 32'h000000F0);
        wr(4'd6, 32'h12345678);
        rd(4'd6, d); check("R2 unmapped reads zero", d, 32'h0);
        rd(4'd0, d); check("R2 unmapped write ignored", d, 32'h0000A5C3);
    endtask

    task automatic t_input();
        logic [31:0] d;
        @(negedge clk); pin_in = 16'h5A5A;
        rd(4'd2, d); check("R4 not yet visible", d, 32'h0);
        rd(4'd2, d); check("R4 input after sync", d, 32'h00005A5A);
        drive_pins(16'h0000);
        wr(4'd3, 32'h0000FFFF);
        rd(4'd3, d); check("R10 disabled no status", d, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        sty[3] = 3'd0; sty[9] = 3'd1;
        apply_styles();
        repeat (2) @(negedge clk);
        rd(4'd3, d); check("R6 active low pin9 set", d, 32'h00000200);
        drive_pins(16'h0208);
        rd(4'd3, d); check("R6 levels follow", d, 32'h00000008);
        wr(4'd3, 32'h0000FFFF);
        rd(4'd3, d); check("R6 level ignores clear", d, 32'h00000008);
        check("R11 irq equals status", {16'h0, pin_irq}, 32'h00000008);
        drive_pins(16'h0000);
        rd(4'd3, d); check("R6 level drops", d, 32'h00000200);
        all_disabled();
        rd(4'd3, d); check("R10 disabled holds", d, 32'h00000200);
        wr(4'd3, 32'h00000200);
        rd(4'd3, d); check("R10 disabled clearable", d, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        sty[0] = 3'd3; sty[12] = 3'd2; sty[15] = 3'd4;
        apply_styles();
        drive_pins(16'h1001);
        rd(4'd3, d); check("R7 rise pin12 only (R5 style-B field 4)", d, 32'h00001000);
        check("R11 irq pin12", {16'h0, pin_irq}, 32'h00001000);
        drive_pins(16'h0000);
        rd(4'd3, d); check("R7 fall pin0, pin12 sticky", d, 32'h00001001);
        wr(4'd3, 32'h00000000);
        rd(4'd3, d); check("R9 write zero keeps", d, 32'h00001001);
        wr(4'd3, 32'h00001000);
        rd(4'd3, d); check("R9 write one clears", d, 32'h00000001);
        drive_pins(16'h8000);
        rd(4'd3, d); check("R8 any rise pin15", d, 32'h00008001);
        wr(4'd3, 32'h0000FFFF);
        drive_pins(16'h0000);
        rd(4'd3, d); check("R8 any fall pin15", d, 32'h00008000);
        wr(4'd3, 32'h0000FFFF);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        sty[5] = 3'd5; sty[6] = 3'd6; sty[3] = 3'd7;
        apply_styles();
        drive_pins(16'h0068);
        drive_pins(16'h0000);
        rd(4'd3, d); check("R10 styles 5-7 silent", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk); pin_in = 16'h1000;   // before edge k
        @(negedge clk);                      // after k
        @(negedge clk);                      // after k+1
        bus_wen = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h00001000;
        @(negedge clk);                      // after k+2
        bus_wen = 1'b0;
        rd(4'd3, d); check("R9 set beats clear", d, 32'h00001000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) sty[i] = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        all_disabled();
        t_input();
        t_levels();
        t_edges();
        t_disabled();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule